// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block takes a single-rank SDR SDRAM from reset to normal operation and then keeps it refreshed. After reset it holds the command bus idle for a 200 us pause. It then runs a fixed script: one precharge of all banks, eight auto-refresh commands, and a load of the mode register. The mode register word carries the configured CAS latency, a burst length of one and sequential burst order. Three cycles after the mode load it raises `init_done`. From then on it issues one auto-refresh each time an internal refresh timer expires. The timer period is 15.6 us, expressed in clocks.

The bus clock frequency is a build parameter. A static configuration word supplies the rest: geometry, CAS latency, bus width and the precharge, row-cycle and row-active times. From the geometry and bus width the block reports the memory capacity as a power of two in bytes. A refresh that falls due while the previous one is still waiting sets a sticky overrun flag, so the loss is not silent.

Top module: `sdram_powerup_seq`

## Requirements
- R1: While `rst_n` is low the outputs are: command NOP, address 0, bank 0, `init_done` 0 and `refresh_overrun` 0. Commands are encoded on {cs_n, ras_n, cas_n, we_n} as follows: NOP=0111, PRECHARGE=0010, AUTO-REFRESH=0001, LOAD-MODE=0000.
- R2: Let P = (CLK_HZ/1000)*200/1000 (at least 1). Count clock edges after reset release from 1. The command bus shows NOP up to edge P-1, and the first non-NOP command appears in cycle P.
- R3: The command in cycle P is PRECHARGE. It drives address bit 10 high, every other address bit low and bank 0.
- R4: Exactly eight AUTO-REFRESH commands follow the precharge. The first comes tRP' cycles after it, where tRP' = max(tRP,1). The spacing between them is G = max(tRC, tRAS+tRP, 1). NOP fills every gap.
- R5: LOAD-MODE follows G cycles after the eighth refresh, with bank 0. Its address carries CAS latency in bits 6:4, 0 in bit 3 (sequential) and 000 in bits 2:0 (burst length 1). All other address bits are 0.
- R6: `init_done` rises exactly 3 cycles after LOAD-MODE, with NOP in between, and stays high until reset.
- R7: The refresh reload is R = 156*(CLK_HZ/1000)/10000 (at least 1). With L the LOAD-MODE cycle, timer expiries fall at edges L+3+kR for k ≥ 1. The first run-time AUTO-REFRESH appears in cycle L+4+R.
- R8: A pending refresh is issued in the first cycle that is both after its expiry edge and at least G cycles after the previous command. Otherwise the bus shows NOP, and PRECHARGE or LOAD-MODE never appears after `init_done`.
- R9: If the timer expires while an earlier request is still waiting and is not being issued on that same edge, `refresh_overrun` goes high and stays high until reset.
- R10: The configuration word is laid out as follows: bits 1:0 NC, 3:2 NR, 4 NB, 7:5 CAS latency, 8 bus16 (1 = 16-bit), 12:9 tRC, 16:13 tRP, 20:17 tRAS. From these fields, `cap_log2` = (8+NC) + (11+NR) + (NB+1) + (bus16 ? 1 : 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_word | input | 21 | Static geometry, CAS latency, bus width and timing word |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | Row address strobe, active low |
| sd_cas_n | output | 1 | Column address strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W (13) | SDRAM address bus |
| sd_ba | output | BA_W (2) | SDRAM bank select |
| init_done | output | 1 | High once the device is in normal mode |
| refresh_overrun | output | 1 | Sticky flag: a refresh request was lost |
| cap_log2 | output | 6 | Capacity as log2 of bytes |

## Verification
The hardest case to reach is a refresh overrun. At a realistic clock the 15.6 us period dwarfs any refresh spacing, so an expiry never meets a request that is still waiting. The bench therefore runs a second instance built for a 1 MHz clock, which gives a 15-cycle reload. That instance is configured with a 30-cycle refresh spacing, so requests pile up and the overrun flag must rise. Back-to-back refreshes with one-cycle spacing are reached by a second phase with all timing fields at zero.

// File: rtl/sdram_seq_pkg.sv
// Shared types for the SDRAM power-up sequencer.
// Assumes a 21-bit configuration word with the field layout given below.
package sdram_seq_pkg;

    // Command encodings on {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } sdr_cmd_e;

    localparam int CFG_W      = 21;
    localparam int F_NC_LO    = 0;
    localparam int F_NR_LO    = 2;
    localparam int F_NB       = 4;
    localparam int F_CAS_LO   = 5;
    localparam int F_BUS16    = 8;
    localparam int F_TRC_LO   = 9;
    localparam int F_TRP_LO   = 13;
    localparam int F_TRAS_LO  = 17;
    localparam int TFIELD_W   = 4;
    localparam int GAP_W      = TFIELD_W + 1;
    localparam int CAP_W      = 6;
    localparam int INIT_REFS  = 8;
    localparam int MRD_CYC    = 3;
    localparam int PRE_ALL_BIT = 10;

endpackage

// File: rtl/sdram_cfg_decode.sv
// Decodes the static configuration word into the quantities the sequencer
// needs: effective precharge wait, refresh spacing, mode word and capacity.
// Assumes ADDR_W > 6 so the mode word fits on the address bus.
module sdram_cfg_decode
    import sdram_seq_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic [CFG_W-1:0]    cfg_word,
    output logic [TFIELD_W-1:0] trp_eff,
    output logic [GAP_W-1:0]    ref_gap,
    output logic [ADDR_W-1:0]   mode_word,
    output logic [CAP_W-1:0]    cap_log2
);

    logic [1:0]          nc, nr;
    logic                nb, bus16;
    logic [2:0]          cas_lat;
    logic [TFIELD_W-1:0] t_rc, t_rp, t_ras;
    logic [GAP_W-1:0]    ras_plus_rp, rc_wide, gap_raw;

    // Split the word into named fields
    always_comb begin
        nc      = cfg_word[F_NC_LO +: 2];
        nr      = cfg_word[F_NR_LO +: 2];
        nb      = cfg_word[F_NB];
        cas_lat = cfg_word[F_CAS_LO +: 3];
        bus16   = cfg_word[F_BUS16];
        t_rc    = cfg_word[F_TRC_LO +: TFIELD_W];
        t_rp    = cfg_word[F_TRP_LO +: TFIELD_W];
        t_ras   = cfg_word[F_TRAS_LO +: TFIELD_W];
    end

    // Precharge wait never shorter than one cycle
    always_comb begin
        trp_eff = (t_rp == '0) ? TFIELD_W'(1) : t_rp;
    end

    // Refresh spacing: larger of row cycle and active+precharge, at least one
    always_comb begin
        ras_plus_rp = GAP_W'(t_ras) + GAP_W'(t_rp);
        rc_wide     = GAP_W'(t_rc);
        gap_raw     = (rc_wide > ras_plus_rp) ? rc_wide : ras_plus_rp;
        ref_gap     = (gap_raw == '0) ? GAP_W'(1) : gap_raw;
    end

    // Mode word: burst length 1, sequential, CAS latency in bits 6:4
    always_comb begin
        mode_word      = '0;
        mode_word[6:4] = cas_lat;
    end

    // Capacity in log2 bytes from geometry and bus width
    always_comb begin
        cap_log2 = CAP_W'(8) + CAP_W'(nc) + CAP_W'(11) + CAP_W'(nr)
                 + CAP_W'(nb) + CAP_W'(1) + (bus16 ? CAP_W'(1) : CAP_W'(2));
    end

endmodule

// File: rtl/sdram_refresh_timer.sv
// Periodic refresh timer. Counts only while enabled, raises a request on each
// expiry, clears it when the sequencer serves it, and flags a lost request.
// Assumes RELOAD >= 1.
module sdram_refresh_timer #(
    parameter int RELOAD = 780
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic serve,
    output logic req_q,
    output logic overrun_q
);

    localparam int TW = (RELOAD < 2) ? 1 : $clog2(RELOAD);

    logic [TW-1:0] cnt_q;
    logic          tick;

    // Expiry when enabled and count has reached zero
    always_comb begin
        tick = run_en && (cnt_q == '0);
    end

    // Down-counter with reload, pending request and sticky overrun
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= TW'(RELOAD - 1);
            req_q     <= 1'b0;
            overrun_q <= 1'b0;
        end else begin
            if (run_en) begin
                cnt_q <= tick ? TW'(RELOAD - 1) : cnt_q - TW'(1);
            end
            req_q     <= tick | (req_q & ~serve);
            overrun_q <= overrun_q | (tick & req_q & ~serve);
        end
    end

endmodule

// File: rtl/sdram_init_fsm.sv
// Power-up script and run-time refresh issue. Holds NOP for PAUSE_CYC cycles,
// then precharge-all, INIT_REFS refreshes, mode load, MRD wait, then normal
// mode. Command, address and bank outputs are registered.
// Assumes ADDR_W > PRE_ALL_BIT and static decode inputs.
module sdram_init_fsm
    import sdram_seq_pkg::*;
#(
    parameter int PAUSE_CYC = 10000,
    parameter int ADDR_W    = 13,
    parameter int BA_W      = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TFIELD_W-1:0] trp_eff,
    input  logic [GAP_W-1:0]    ref_gap,
    input  logic [ADDR_W-1:0]   mode_word,
    input  logic                refresh_req,
    output sdr_cmd_e            cmd_q,
    output logic [ADDR_W-1:0]   addr_q,
    output logic [BA_W-1:0]     ba_q,
    output logic                init_done_q,
    output logic                serve
);

    localparam int PW = $clog2(PAUSE_CYC + 1);
    localparam int WW = (PW > GAP_W + 1) ? PW : GAP_W + 1;
    localparam int RC_W = $clog2(INIT_REFS + 1);

    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_INITREF,
        ST_LOADMODE,
        ST_MRD,
        ST_RUN
    } seq_state_e;

    seq_state_e       state_q;
    logic [WW-1:0]    wait_q;
    logic [RC_W-1:0]  refs_left_q;
    logic             act;

    // Ready to act once the wait counter has drained
    always_comb begin
        act   = (wait_q == '0);
        serve = act && (state_q == ST_RUN) && refresh_req;
    end

    // Sequencer state, wait counter and registered command bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_PAUSE;
            wait_q      <= WW'(PAUSE_CYC - 1);
            refs_left_q <= RC_W'(INIT_REFS);
            cmd_q       <= CMD_NOP;
            addr_q      <= '0;
            ba_q        <= '0;
            init_done_q <= 1'b0;
        end else begin
            cmd_q  <= CMD_NOP;
            addr_q <= '0;
            ba_q   <= '0;
            if (!act) begin
                wait_q <= wait_q - WW'(1);
            end else begin
                unique case (state_q)
                    ST_PAUSE: begin
                        cmd_q               <= CMD_PRE;
                        addr_q[PRE_ALL_BIT] <= 1'b1;
                        wait_q              <= WW'(trp_eff) - WW'(1);
                        refs_left_q         <= RC_W'(INIT_REFS);
                        state_q             <= ST_INITREF;
                    end
                    ST_INITREF: begin
                        cmd_q       <= CMD_REF;
                        wait_q      <= WW'(ref_gap) - WW'(1);
                        refs_left_q <= refs_left_q - RC_W'(1);
                        if (refs_left_q == RC_W'(1)) begin
                            state_q <= ST_LOADMODE;
                        end
                    end
                    ST_LOADMODE: begin
                        cmd_q   <= CMD_LMR;
                        addr_q  <= mode_word;
                        wait_q  <= WW'(MRD_CYC - 1);
                        state_q <= ST_MRD;
                    end
                    ST_MRD: begin
                        init_done_q <= 1'b1;
                        state_q     <= ST_RUN;
                    end
                    ST_RUN: begin
                        if (refresh_req) begin
                            cmd_q  <= CMD_REF;
                            wait_q <= WW'(ref_gap) - WW'(1);
                        end
                    end
                    default: state_q <= ST_PAUSE;
                endcase
            end
        end
    end

endmodule

// File: rtl/sdram_powerup_seq.sv
// Top of the SDRAM power-up and refresh sequencer. Derives the pause length
// and refresh reload from CLK_HZ, decodes the configuration word, and joins
// the script sequencer with the refresh timer.
// Assumes cfg_word is stable while rst_n is high.
module sdram_powerup_seq
    import sdram_seq_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000,
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg_word,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [BA_W-1:0]   sd_ba,
    output logic              init_done,
    output logic              refresh_overrun,
    output logic [CAP_W-1:0]  cap_log2
);

    localparam int PAUSE_RAW  = (CLK_HZ / 1000) * 200 / 1000;
    localparam int PAUSE_CYC  = (PAUSE_RAW < 1) ? 1 : PAUSE_RAW;
    localparam int RELOAD_RAW = 156 * (CLK_HZ / 1000) / 10000;
    localparam int REF_RELOAD = (RELOAD_RAW < 1) ? 1 : RELOAD_RAW;

    logic [TFIELD_W-1:0] trp_eff;
    logic [GAP_W-1:0]    ref_gap;
    logic [ADDR_W-1:0]   mode_word;
    logic                refresh_req, serve;
    sdr_cmd_e            cmd_q;

    sdram_cfg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .cfg_word  (cfg_word),
        .trp_eff   (trp_eff),
        .ref_gap   (ref_gap),
        .mode_word (mode_word),
        .cap_log2  (cap_log2)
    );

    sdram_init_fsm #(
        .PAUSE_CYC (PAUSE_CYC),
        .ADDR_W    (ADDR_W),
        .BA_W      (BA_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .trp_eff     (trp_eff),
        .ref_gap     (ref_gap),
        .mode_word   (mode_word),
        .refresh_req (refresh_req),
        .cmd_q       (cmd_q),
        .addr_q      (sd_addr),
        .ba_q        (sd_ba),
        .init_done_q (init_done),
        .serve       (serve)
    );

    sdram_refresh_timer #(.RELOAD(REF_RELOAD)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (init_done),
        .serve     (serve),
        .req_q     (refresh_req),
        .overrun_q (refresh_overrun)
    );

    // Drive the command pins from the registered command
    always_comb begin
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = 4'(cmd_q);
    end

endmodule

// File: rtl/sdram_powerup_seq_chk.sv
// Assertion checker for the sequencer, attached to every instance by bind.
module sdram_powerup_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic a10,
    input logic init_done,
    input logic refresh_overrun
);

    logic [3:0] cmd;
    always_comb cmd = {cs_n, ras_n, cas_n, we_n};

    // R3: precharge always addresses all banks
    a_r3_pre_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0010) |-> a10);

    // R6: normal mode holds until reset
    a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // R6: no command in the cycle normal mode begins
    a_r6_quiet_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> (cmd == 4'b0111));

    // R8: no mode load or precharge once in normal mode
    a_r8_no_script_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (cmd != 4'b0000 && cmd != 4'b0010));

    // R9: overrun flag is sticky
    a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_overrun |=> refresh_overrun);

    // R9: overrun only possible once the timer runs
    a_r9_overrun_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_overrun |-> init_done);

endmodule

bind sdram_powerup_seq sdram_powerup_seq_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cs_n            (sd_cs_n),
    .ras_n           (sd_ras_n),
    .cas_n           (sd_cas_n),
    .we_n            (sd_we_n),
    .a10             (sd_addr[10]),
    .init_done       (init_done),
    .refresh_overrun (refresh_overrun)
);

// File: tb/sdram_powerup_seq_bench.sv
`timescale 1ns/1ps

// Behavioural reference: expected bus per cycle computed from the requirements.
module sdram_powerup_seq_model #(
    parameter int CLK_HZ = 50_000_000,
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [20:0]       cfg,
    output logic [3:0]        cmd,
    output logic [ADDR_W-1:0] addr,
    output logic              done,
    output logic              ov,
    output logic [5:0]        cap
);
    int e, ready_at, p, r, trp, g, l;
    bit pend, serve, tick;

    always_comb begin
        cap = 6'(8 + int'(cfg[1:0]) + 11 + int'(cfg[3:2]) + int'(cfg[4]) + 1
                 + (cfg[8] ? 1 : 2));
    end

    always @(posedge clk) begin
        p   = (CLK_HZ / 1000) * 200 / 1000; if (p < 1) p = 1;
        r   = 156 * (CLK_HZ / 1000) / 10000; if (r < 1) r = 1;
        trp = int'(cfg[16:13]);
        g   = int'(cfg[20:17]) + trp;
        if (int'(cfg[12:9]) > g) g = int'(cfg[12:9]);
        if (g < 1) g = 1;
        if (trp < 1) trp = 1;
        l   = p + trp + 8 * g;
        if (!rst_n) begin
            e = 0; ready_at = 0; pend = 0; ov = 0;
            cmd = 4'b0111; addr = '0; done = 0;
        end else begin
            e++;
            cmd = 4'b0111; addr = '0;
            if (e == p) begin
                cmd = 4'b0010; addr[10] = 1'b1;
            end else if (e >= p + trp && e < l && (e - p - trp) % g == 0) begin
                cmd = 4'b0001;
            end else if (e == l) begin
                cmd = 4'b0000; addr[6:4] = cfg[7:5];
            end
            done = (e >= l + 3);
            if (e >= l + 4) begin
                serve = pend && (e >= ready_at);
                tick  = ((e - l - 3) % r) == 0;
                if (serve) begin
                    cmd = 4'b0001; ready_at = e + g;
                end
                if (tick && pend && !serve) ov = 1;
                pend = tick || (pend && !serve);
            end
        end
    end
endmodule

module sdram_powerup_seq_bench;
    logic clk = 0;
    logic rst_n = 0;
    logic [20:0] cfg_a, cfg_b;
    int checks = 0, fails = 0;

    always #10 clk = ~clk;

    logic        cs_a, ras_a, cas_a, we_a, done_a, ov_a;
    logic [12:0] addr_a; logic [1:0] ba_a; logic [5:0] cap_a;
    logic        cs_b, ras_b, cas_b, we_b, done_b, ov_b;
    logic [12:0] addr_b; logic [1:0] ba_b; logic [5:0] cap_b;

    sdram_powerup_seq u_sdram_powerup_seq (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_a),
        .sd_cs_n(cs_a), .sd_ras_n(ras_a), .sd_cas_n(cas_a), .sd_we_n(we_a),
        .sd_addr(addr_a), .sd_ba(ba_a), .init_done(done_a),
        .refresh_overrun(ov_a), .cap_log2(cap_a));

    sdram_powerup_seq #(.CLK_HZ(1_000_000)) u_slow (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_b),
        .sd_cs_n(cs_b), .sd_ras_n(ras_b), .sd_cas_n(cas_b), .sd_we_n(we_b),
        .sd_addr(addr_b), .sd_ba(ba_b), .init_done(done_b),
        .refresh_overrun(ov_b), .cap_log2(cap_b));

    logic [3:0]  ecmd_a, ecmd_b;
    logic [12:0] eaddr_a, eaddr_b;
    logic        edone_a, edone_b, eov_a, eov_b;
    logic [5:0]  ecap_a, ecap_b;

    sdram_powerup_seq_model #(.CLK_HZ(50_000_000)) m_a (
        .clk(clk), .rst_n(rst_n), .cfg(cfg_a), .cmd(ecmd_a), .addr(eaddr_a),
        .done(edone_a), .ov(eov_a), .cap(ecap_a));
    sdram_powerup_seq_model #(.CLK_HZ(1_000_000)) m_b (
        .clk(clk), .rst_n(rst_n), .cfg(cfg_b), .cmd(ecmd_b), .addr(eaddr_b),
        .done(edone_b), .ov(eov_b), .cap(ecap_b));

    function automatic logic [20:0] mk_cfg(int nc, int nr, int nb, int cas,
                                           int b16, int trc, int trp, int tras);
        return {4'(tras), 4'(trp), 4'(trc), 1'(b16), 3'(cas), 1'(nb), 2'(nr), 2'(nc)};
    endfunction

    function automatic string tag_of(logic [3:0] ec, logic ed, logic dm, logic om, logic cm);
        if (dm) return "R6";
        if (om) return "R9";
        if (cm) return "R10";
        case (ec)
            4'b0010: return "R3";
            4'b0000: return "R5";
            4'b0001: return ed ? "R8" : "R4";
            default: return ed ? "R8" : "R2";
        endcase
    endfunction

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison of both instances against their models
    always @(negedge clk) begin
        if (rst_n) begin
            logic [19:0] act_v, exp_v;
            act_v = {cs_a, ras_a, cas_a, we_a, addr_a, ba_a, done_a};
            exp_v = {ecmd_a, eaddr_a, 2'b00, edone_a};
            checks++;
            if (act_v != exp_v || ov_a != eov_a || cap_a != ecap_a) begin
                fails++;
                $display("FAIL %s inst_a bus actual=%h/%b expected=%h/%b",
                    tag_of(ecmd_a, edone_a, done_a != edone_a, ov_a != eov_a,
                           cap_a != ecap_a), act_v, ov_a, exp_v, eov_a);
            end
            act_v = {cs_b, ras_b, cas_b, we_b, addr_b, ba_b, done_b};
            exp_v = {ecmd_b, eaddr_b, 2'b00, edone_b};
            checks++;
            if (act_v != exp_v || ov_b != eov_b || cap_b != ecap_b) begin
                fails++;
                $display("FAIL %s inst_b bus actual=%h/%b expected=%h/%b",
                    tag_of(ecmd_b, edone_b, done_b != edone_b, ov_b != eov_b,
                           cap_b != ecap_b), act_v, ov_b, exp_v, eov_b);
            end
        end
    end

    // Track the first run-time refresh of instance A (R7)
    int cyc = 0, first_ref = -1;
    always @(posedge clk) cyc = rst_n ? cyc + 1 : 0;
    always @(negedge clk) begin
        if (!rst_n) first_ref = -1;
        else if (first_ref < 0 && done_a && {cs_a, ras_a, cas_a, we_a} == 4'b0001)
            first_ref = cyc;
    end

    task automatic reset_phase(logic [20:0] ca, logic [20:0] cb, int cap_ea, int cap_eb);
        @(posedge clk); #1;
        rst_n = 0; cfg_a = ca; cfg_b = cb;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state on both instances
        check("R1", int'({cs_a, ras_a, cas_a, we_a}), 7, "cmd_a");
        check("R1", int'({addr_a, ba_a, done_a, ov_a}), 0, "addr/ba/done/ov_a");
        check("R1", int'({cs_b, ras_b, cas_b, we_b}), 7, "cmd_b");
        check("R1", int'({addr_b, ba_b, done_b, ov_b}), 0, "addr/ba/done/ov_b");
        // R10: capacity from geometry fields
        check("R10", int'(cap_a), cap_ea, "cap_a");
        check("R10", int'(cap_b), cap_eb, "cap_b");
        @(posedge clk); #1;
        rst_n = 1;
    endtask

    int l_exp;
    initial begin
        cfg_a = '0; cfg_b = '0;
        // Phase 1: G=8 on A; G=30 vs R=15 on B forces overrun
        reset_phase(mk_cfg(1, 2, 1, 3, 0, 7, 3, 5), mk_cfg(3, 3, 1, 2, 0, 15, 15, 15), 26, 29);
        repeat (13000) @(posedge clk);
        @(negedge clk);
        l_exp = 10000 + 3 + 8 * 8;
        check("R7", first_ref, l_exp + 4 + 780, "first run-time refresh cycle");
        check("R9", int'(ov_b), 1, "overrun on slow instance");
        check("R9", int'(ov_a), 0, "no overrun on fast instance");
        check("R6", int'(done_a & done_b), 1, "init_done both");
        // Phase 2: all-zero timings (back-to-back refreshes), 16-bit bus
        reset_phase(mk_cfg(0, 0, 0, 2, 1, 0, 0, 0), mk_cfg(2, 1, 0, 3, 1, 2, 2, 1), 21, 24);
        repeat (13000) @(posedge clk);
        @(negedge clk);
        l_exp = 10000 + 1 + 8 * 1;
        check("R7", first_ref, l_exp + 4 + 780, "first run-time refresh cycle");
        check("R9", int'(ov_a), 0, "no overrun instance A");
        check("R9", int'(ov_b), 0, "no overrun instance B");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #(20 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule